// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Word-Boundary Slip

This block turns a serial bit stream into parallel words. The serial input is sampled on a fast clock. A complete word is handed to the surrounding logic on a slow clock, which must be phase-aligned with the fast clock and run at the fast rate divided by the number of fast cycles per word. The block has two capture modes, set at elaboration time. In single-rate mode one bit is taken on each rising fast edge. In double-rate mode one bit is taken on the rising edge and one on the falling edge.

Framing is adjusted from outside. The serial stream has no inherent word boundary, so a controller pulses the slip input until the parallel words match a known training pattern. Each pulse moves the boundary by one bit. The block keeps a history of the last two words' worth of bits and selects a word-sized window from that history. Each pulse moves the window one bit further back in time.

Top module: `bitstream_deser`

## Requirements
- R1: Single-rate mode samples `sdata` on each rising edge of `fclk` and accepts word widths 2 to 8. At zero slip offset, the word loaded at a rising `sclk` edge holds the RATIO bits sampled on the RATIO rising `fclk` edges just before that edge.
- R2: Double-rate mode samples `sdata` on the rising and then the falling edge of `fclk` and accepts word widths 4, 6 and 8. At zero slip offset, the word loaded at a rising `sclk` edge ends with the bit from the falling `fclk` edge two fast cycles earlier and holds the RATIO bits up to that one.
- R3: Inside a word, the earliest received bit sits in bit RATIO-1 (MSB) and the latest in bit 0. Successive words at a constant offset cover adjacent, non-overlapping stretches of the stream.
- R4: A mode and width pair outside the legal sets of R1 and R2 stops elaboration with an error.
- R5: A `bitslip` pulse one `sclk` cycle wide, sampled at a rising `sclk` edge, increases the slip offset by one. Every word loaded from the next edge onward is made of bits one position earlier in the stream. While `bitslip` is low the offset does not change.
- R6: After RATIO slip pulses, the offset returns to zero and the framing is the same as before the first pulse.
- R7: `pword` changes only at a rising `sclk` edge (or on reset) and holds its value for the whole slow cycle.
- R8: While `rst` is high (active high, asynchronous), `pword` reads zero and both the capture history and the slip offset are cleared. Framing after release uses offset zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk | input | 1 | Fast bit clock used to sample the serial input |
| sclk | input | 1 | Slow word clock, phase-aligned with fclk |
| rst | input | 1 | Active-high asynchronous reset |
| sdata | input | 1 | Serial data input |
| bitslip | input | 1 | Slip request, one sclk cycle wide per bit of shift |
| pword | output | RATIO | Parallel word, MSB holds the earliest bit |

## Verification
Assertions run on every cycle. They check that the capture history shifts by exactly the bits taken in one fast cycle. They check that the slip offset advances by one, wrapping at the word width, on each sampled request and stays unchanged otherwise. They also check that the MSB of each loaded word comes from the history position the offset selects. Only the bench scenarios can show the full relation between the serial stream and whole words: the bit order, the latency through the capture registers, the return to the original framing after a full turn of slips, the holding of words across a slow cycle, and the clearing of the offset by a reset in the middle of a run. The bench runs both capture modes side by side on a shared slow clock.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Capture mode: one bit per fast cycle or one per fast edge.
  typedef enum logic {
    CAP_SDR = 1'b0,
    CAP_DDR = 1'b1
  } cap_mode_e;

  // Legal word widths for each capture mode.
  function automatic bit ratio_ok(cap_mode_e m, int r);
    if (m == CAP_SDR) return (r >= 2) && (r <= 8);
    return (r == 4) || (r == 6) || (r == 8);
  endfunction

  // Number of bits entering the history on each rising fast edge.
  function automatic int bits_per_fast(cap_mode_e m);
    return (m == CAP_DDR) ? 2 : 1;
  endfunction

  // Slip offset after one request, wrapping at the word width.
  function automatic int next_offset(int off, int r);
    return (off + 1 >= r) ? 0 : off + 1;
  endfunction

endpackage

// File: rtl/deser_capture.sv
module deser_capture
  import deser_pkg::*;
#(
  parameter cap_mode_e MODE  = CAP_DDR,
  parameter int        RATIO = 8
) (
  input  logic               fclk,
  input  logic               rst,
  input  logic               sdata,
  output logic [2*RATIO-1:0] hist
);

  localparam int HIST_W = 2 * RATIO;
  localparam int STEP   = bits_per_fast(MODE);

  // Bits entering the history on the next rising fast edge, oldest first.
  logic [STEP-1:0] incoming;

  generate
    if (MODE == CAP_DDR) begin : g_ddr
      logic rise_q;
      logic fall_q;

      always_ff @(posedge fclk or posedge rst) begin
        if (rst) rise_q <= 1'b0;
        else     rise_q <= sdata;
      end

      always_ff @(negedge fclk or posedge rst) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= sdata;
      end

      // The rising-edge bit precedes the falling-edge bit in the stream.
      assign incoming = {rise_q, fall_q};
    end else begin : g_sdr
      assign incoming = sdata;
    end
  endgenerate

  always_ff @(posedge fclk or posedge rst) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HIST_W-1-STEP:0], incoming};
  end

  // R1 / R2: older bits move up by exactly one fast cycle's worth of bits.
  a_r1_history_shift: assert property (@(posedge fclk) disable iff (rst)
    1'b1 |=> hist[HIST_W-1:STEP] == $past(hist[HIST_W-1-STEP:0]));

endmodule

// File: rtl/deser_slip.sv
module deser_slip
  import deser_pkg::*;
#(
  parameter int RATIO = 8
) (
  input  logic                     sclk,
  input  logic                     rst,
  input  logic                     bitslip,
  output logic [$clog2(RATIO)-1:0] offset
);

  localparam int OFF_W = $clog2(RATIO);

  // Slip request accepted at this slow edge.
  logic slip_take;
  assign slip_take = bitslip;

  always_ff @(posedge sclk or posedge rst) begin
    if (rst)            offset <= '0;
    else if (slip_take) offset <= OFF_W'(next_offset(int'(offset), RATIO));
  end

  // R5: each accepted request moves the offset by exactly one.
  a_r5_slip_advance: assert property (@(posedge sclk) disable iff (rst)
    bitslip |=> int'(offset) == next_offset(int'($past(offset)), RATIO));

  // R5: without a request the offset stays put.
  a_r5_slip_idle: assert property (@(posedge sclk) disable iff (rst)
    !bitslip |=> $stable(offset));

  // R6: a request at the last offset returns to the original framing.
  a_r6_slip_wrap: assert property (@(posedge sclk) disable iff (rst)
    (bitslip && int'(offset) == RATIO - 1) |=> offset == '0);

endmodule

// File: rtl/deser_framer.sv
module deser_framer #(
  parameter int RATIO = 8
) (
  input  logic                     sclk,
  input  logic                     rst,
  input  logic [2*RATIO-1:0]       hist,
  input  logic [$clog2(RATIO)-1:0] offset,
  output logic [RATIO-1:0]         pword
);

  // Word-sized window, pushed back in time by the slip offset.
  logic [RATIO-1:0] window;
  assign window = RATIO'(hist >> offset);

  always_ff @(posedge sclk or posedge rst) begin
    if (rst) pword <= '0;
    else     pword <= window;
  end

  // R3: the MSB of a loaded word is the oldest bit of the selected window.
  a_r3_msb_oldest: assert property (@(posedge sclk) disable iff (rst)
    1'b1 |=> pword[RATIO-1] == $past(hist[RATIO-1+int'(offset)]));

endmodule

// File: rtl/bitstream_deser.sv
module bitstream_deser
  import deser_pkg::*;
#(
  parameter cap_mode_e MODE  = CAP_DDR,
  parameter int        RATIO = 8
) (
  input  logic             fclk,
  input  logic             sclk,
  input  logic             rst,
  input  logic             sdata,
  input  logic             bitslip,
  output logic [RATIO-1:0] pword
);

  localparam int HIST_W = 2 * RATIO;
  localparam int OFF_W  = $clog2(RATIO);

  // R4: reject width and mode pairs outside the legal sets.
  generate
    if (!ratio_ok(MODE, RATIO)) begin : g_illegal_ratio
      $error("bitstream_deser: word width %0d not legal for the chosen capture mode", RATIO);
    end
  endgenerate

  logic [HIST_W-1:0] hist;
  logic [OFF_W-1:0]  offset;

  deser_capture #(.MODE(MODE), .RATIO(RATIO)) u_capture (
    .fclk  (fclk),
    .rst   (rst),
    .sdata (sdata),
    .hist  (hist)
  );

  deser_slip #(.RATIO(RATIO)) u_slip (
    .sclk    (sclk),
    .rst     (rst),
    .bitslip (bitslip),
    .offset  (offset)
  );

  deser_framer #(.RATIO(RATIO)) u_framer (
    .sclk   (sclk),
    .rst    (rst),
    .hist   (hist),
    .offset (offset),
    .pword  (pword)
  );

endmodule

// File: tb/bitstream_deser_tb_top.sv
`timescale 1ns/100ps
module bitstream_deser_tb_top;
  import deser_pkg::*;

  localparam int DR = 8;   // double-rate instance width
  localparam int SR = 4;   // single-rate instance width
  localparam int VEC_N = 6;
  localparam int VEC_SLIPS [VEC_N] = '{0, 1, 2, 3, 2, 1};
  localparam int VEC_RUN   [VEC_N] = '{4, 3, 3, 3, 3, 3};

  logic fclk = 1'b0, sclk = 1'b0, rst = 1'b1, bitslip = 1'b0;
  logic sd_ddr = 1'b0, sd_sdr = 1'b0;
  logic [DR-1:0] pw_ddr;
  logic [SR-1:0] pw_sdr;

  int nchk = 0, nfail = 0;
  int off_d = 0, off_s = 0, slips_total = 0;
  bit done = 1'b0;

  bitstream_deser #(.MODE(CAP_DDR), .RATIO(DR)) dut_i (
    .fclk(fclk), .sclk(sclk), .rst(rst), .sdata(sd_ddr), .bitslip(bitslip), .pword(pw_ddr));

  bitstream_deser #(.MODE(CAP_SDR), .RATIO(SR)) dut_sdr_i (
    .fclk(fclk), .sclk(sclk), .rst(rst), .sdata(sd_sdr), .bitslip(bitslip), .pword(pw_sdr));

  // 100 MHz fast clock; slow clock rises with every fourth fast rising edge.
  initial begin
    int ph;
    ph = 0;
    forever begin
      #5 fclk = 1'b1;
      if (ph == 0) sclk = 1'b1;
      else if (ph == 2) sclk = 1'b0;
      ph = (ph + 1) % 4;
      #5 fclk = 1'b0;
    end
  end

  function automatic logic pat(longint n);
    logic [31:0] x;
    if (n < 0) return 1'b0;
    x = 32'(n) * 32'h9E3779B1;
    return x[17] ^ x[11] ^ x[29];
  endfunction

  // Stream bit n for the double-rate input is sampled at 5+5n ns;
  // stream bit m for the single-rate input is sampled at 5+10m ns.
  initial begin
    #2.5;
    for (longint s = 0; s >= 0; s++) begin
      sd_ddr = pat(s);
      if (s % 2 == 0) sd_sdr = pat(s / 2);
      #5;
    end
  end

  function automatic logic [DR-1:0] exp_ddr(longint k, int o);
    logic [DR-1:0] w;
    for (int i = 0; i < DR; i++) w[i] = pat(2 * k - 3 - i - o);
    return w;
  endfunction

  function automatic logic [SR-1:0] exp_sdr(longint k, int o);
    logic [SR-1:0] w;
    for (int i = 0; i < SR; i++) w[i] = pat(k - 1 - i - o);
    return w;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One slow cycle: sample word after the edge, recheck before the next edge,
  // then drive the slip request seen at the following edge.
  task automatic slow_cycle(logic slip_next, bit check_en, string tag);
    longint k;
    logic slip_now;
    logic [DR-1:0] d12;
    logic [SR-1:0] s12;
    string td, ts;
    @(posedge sclk);
    k = (longint'($time) - 5) / 10;
    slip_now = bitslip;
    #12;
    d12 = pw_ddr;
    s12 = pw_sdr;
    if (tag != "") begin
      td = {tag, " ddr"}; ts = {tag, " sdr"};
    end else begin
      td = (off_d != 0) ? "R5 ddr slipped word" :
           (slips_total >= DR) ? "R6 ddr wrapped word" : "R2 R3 ddr word";
      ts = (off_s != 0) ? "R5 sdr slipped word" :
           (slips_total >= SR) ? "R6 sdr wrapped word" : "R1 R3 sdr word";
    end
    if (check_en) begin
      chk(td, d12, exp_ddr(k, off_d));
      chk(ts, {4'b0, s12}, {4'b0, exp_sdr(k, off_s)});
    end
    #20;
    if (check_en) begin
      chk("R7 ddr hold", pw_ddr, d12);
      chk("R7 sdr hold", {4'b0, pw_sdr}, {4'b0, s12});
    end
    if (slip_now) begin
      off_d = (off_d + 1) % DR;
      off_s = (off_s + 1) % SR;
      slips_total++;
    end
    bitslip = slip_next;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R8: reset state.
    repeat (2) @(posedge sclk);
    #12;
    chk("R8 reset ddr", pw_ddr, 8'h00);
    chk("R8 reset sdr", {4'b0, pw_sdr}, 8'h00);

    // R4: legal width sets per mode.
    chk("R4 sdr 1",  {7'b0, ratio_ok(CAP_SDR, 1)},  8'h00);
    chk("R4 sdr 2",  {7'b0, ratio_ok(CAP_SDR, 2)},  8'h01);
    chk("R4 sdr 8",  {7'b0, ratio_ok(CAP_SDR, 8)},  8'h01);
    chk("R4 sdr 9",  {7'b0, ratio_ok(CAP_SDR, 9)},  8'h00);
    chk("R4 ddr 2",  {7'b0, ratio_ok(CAP_DDR, 2)},  8'h00);
    chk("R4 ddr 5",  {7'b0, ratio_ok(CAP_DDR, 5)},  8'h00);
    chk("R4 ddr 6",  {7'b0, ratio_ok(CAP_DDR, 6)},  8'h01);
    chk("R4 ddr 10", {7'b0, ratio_ok(CAP_DDR, 10)}, 8'h00);
    rst = 1'b0;

    repeat (3) slow_cycle(1'b0, 1'b0, "");

    // Vector table: slip pulses, then plain words at the new framing.
    for (int v = 0; v < VEC_N; v++) begin
      repeat (VEC_SLIPS[v]) begin
        slow_cycle(1'b1, 1'b1, "");
        slow_cycle(1'b0, 1'b1, "");
      end
      repeat (VEC_RUN[v]) slow_cycle(1'b0, 1'b1, "");
    end

    // R8: reset in mid-run clears a nonzero offset.
    repeat (3) begin
      slow_cycle(1'b1, 1'b1, "");
      slow_cycle(1'b0, 1'b1, "");
    end
    @(posedge sclk);
    #12;
    rst = 1'b1;
    #20;
    chk("R8 mid reset ddr", pw_ddr, 8'h00);
    chk("R8 mid reset sdr", {4'b0, pw_sdr}, 8'h00);
    @(posedge sclk);
    #12;
    chk("R8 held reset ddr", pw_ddr, 8'h00);
    chk("R8 held reset sdr", {4'b0, pw_sdr}, 8'h00);
    rst = 1'b0;
    off_d = 0;
    off_s = 0;
    slips_total = 0;
    repeat (3) slow_cycle(1'b0, 1'b0, "");
    repeat (4) slow_cycle(1'b0, 1'b1, "R8 offset cleared");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule